// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Handshake and Receive Controller

This block holds the control and status logic of one bulk OUT endpoint in a full-speed USB device. A protocol engine in front of it reports decoded events: an OUT token was seen, packet bytes arrived, the packet ended (good or bad), the host broke the protocol, the host sent CLEAR_FEATURE for this endpoint, and whether a transaction is in progress. For every OUT token the block answers one cycle later with the handshake to return: ACK, NAK or STALL.

Accepted packet data lands in one of two 64-byte packet buffers. The CPU drains them one byte per read strobe through a small register port, oldest packet first. The same port exposes a status register with write-one-to-clear flags, an interrupt-enable bit, and an interrupt flag that drives `irq`.

Software can ask for a stall by setting a force flag. The block enters the stall only when no transaction is in progress. On entry it raises a sent flag and drops the force flag in the same cycle. A stall raised by the hardware because of a protocol violation works in the same way on the bus but never shows in the status register. Both kinds of stall end on CLEAR_FEATURE.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset, `hs_valid` and `irq` are low and the status register (address 0) and interrupt register (address 2) read as zero.
- R2: An `tok_out` pulse produces `hs_valid` high for exactly one cycle on the next clock, with `hs_code` 0 = ACK, 1 = NAK, 2 = STALL. The code is ACK when no stall is active and at least one buffer is free.
- R3: A packet that was answered with ACK and ends with `rx_end` and `rx_ok` high sets status bit 0 (packet done). If status bit 4 (receive interrupt enable) is set, it also sets interrupt register bit 0 and `irq`. A packet that ends with `rx_ok` low sets nothing and stores nothing.
- R4: Status bit 0, status bit 2 and interrupt bit 0 clear only when software writes 1 to them. Writing 0 leaves them unchanged. Status bit 4 is written directly.
- R5: While both buffers hold unread data, OUT tokens get NAK, and the bytes of that packet are discarded.
- R6: Writing 1 to status bit 3 sets the force-stall request. While `txn_busy` is high the request waits. On the first clock with `txn_busy` low, the stall is entered: status bit 2 (stall sent) becomes 1 and bit 3 becomes 0 on the same edge.
- R7: While a software stall is active, every OUT token gets STALL until `clr_feat`. After that, tokens get ACK or NAK as usual even if status bit 2 is still set.
- R8: `proto_err` makes every later OUT token get STALL until `clr_feat`, and never sets status bit 2.
- R9: A read strobe at address 1 returns the oldest unread byte and advances to the next one, crossing from one packet to the next in arrival order. Status bit 1 is high while any byte is unread. Stored data stays readable during and after a stall.
- R10: Bytes beyond the 64th of one packet are dropped, and the packet keeps its first 64 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | OUT token addressed to this endpoint (one-cycle pulse) |
| rx_we | input | 1 | Received data byte valid |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | End of data packet (one-cycle pulse) |
| rx_ok | input | 1 | Qualifies `rx_end`: packet received without error |
| proto_err | input | 1 | Host protocol violation seen (one-cycle pulse) |
| clr_feat | input | 1 | CLEAR_FEATURE for this endpoint (one-cycle pulse) |
| txn_busy | input | 1 | A bus transaction is in progress |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| reg_addr | input | 2 | Register select: 0 status, 1 data, 2 interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops a byte at address 1) |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Receive interrupt |

## Verification
The handshake decision is tried in every buffer state: both buffers free, one full, both full, and with bytes drained from the head buffer between tokens. This separates an ACK that comes from a freed buffer from a NAK that comes from full storage. Stalls are driven three ways: a force request made while `txn_busy` is high, one made while it is low, and a protocol error. The three differ only in when the stall starts and in whether status bit 2 rises. Tokens after `clr_feat` with the sent flag still set show that clearing the stall does not depend on that flag. Packet endings cover a good end with the interrupt enabled, a good end with it disabled, a bad end, an over-long packet and a NAKed packet, so each combination of flag update and data storage is observed.

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl #(
  parameter int BUF_BYTES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_out,
  input  logic       rx_we,
  input  logic [7:0] rx_byte,
  input  logic       rx_end,
  input  logic       rx_ok,
  input  logic       proto_err,
  input  logic       clr_feat,
  input  logic       txn_busy,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [4:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);

  localparam int PW = $clog2(BUF_BYTES + 1);
  localparam int AW = $clog2(BUF_BYTES);
  localparam logic [PW-1:0] CAP = PW'(BUF_BYTES);
  localparam logic [1:0] HS_ACK = 2'd0;
  localparam logic [1:0] HS_NAK = 2'd1;
  localparam logic [1:0] HS_STALL = 2'd2;

  logic [7:0]    mem [0:1][0:BUF_BYTES-1];
  logic [PW-1:0] blen [0:1];
  logic [1:0]    full;
  logic          wsel, rsel, acc;
  logic [PW-1:0] wptr, rptr;
  logic          rpc, sst, fst, ien, intf;
  logic          stall_sw, stall_pe;

  logic stalled, both_full, free_sel, rne, pop, last, fst_go;
  logic st_wr, int_wr, byte_wr, commit, rpc_set;
  logic [1:0] hs_next;

  assign stalled   = stall_sw | stall_pe;
  assign both_full = &full;
  assign free_sel  = full[rsel] ? ~rsel : rsel;
  assign rne       = full[rsel];
  assign pop       = reg_rd && reg_addr == 2'd1 && rne;
  assign last      = (rptr + 1'b1) == blen[rsel];
  assign fst_go    = fst && !txn_busy && !clr_feat;
  assign st_wr     = reg_wr && reg_addr == 2'd0;
  assign int_wr    = reg_wr && reg_addr == 2'd2;
  assign byte_wr   = acc && !tok_out && !rx_end && rx_we && wptr < CAP;
  assign commit    = acc && !tok_out && rx_end;
  assign rpc_set   = commit && rx_ok;
  assign hs_next   = stalled ? HS_STALL : both_full ? HS_NAK : HS_ACK;
  assign irq       = intf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
      full     <= 2'b00;
      blen[0]  <= '0;
      blen[1]  <= '0;
      wsel     <= 1'b0;
      rsel     <= 1'b0;
      acc      <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      rpc      <= 1'b0;
      sst      <= 1'b0;
      fst      <= 1'b0;
      ien      <= 1'b0;
      intf     <= 1'b0;
      stall_sw <= 1'b0;
      stall_pe <= 1'b0;
    end else begin
      hs_valid <= tok_out;
      if (tok_out) begin
        hs_code <= hs_next;
        acc     <= hs_next == HS_ACK;
        wsel    <= free_sel;
        wptr    <= '0;
      end else if (commit) begin
        acc <= 1'b0;
        if (rx_ok && wptr != '0) begin
          full[wsel] <= 1'b1;
          blen[wsel] <= wptr;
        end
      end else if (byte_wr) begin
        wptr <= wptr + 1'b1;
      end

      if (pop) begin
        if (last) begin
          full[rsel] <= 1'b0;
          rptr       <= '0;
          rsel       <= ~rsel;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end

      rpc      <= rpc_set | (rpc & ~(st_wr & reg_wdata[0]));
      intf     <= (rpc_set & ien) | (intf & ~(int_wr & reg_wdata[0]));
      ien      <= st_wr ? reg_wdata[4] : ien;
      fst      <= (st_wr & reg_wdata[3]) | (fst & ~fst_go);
      sst      <= fst_go | (sst & ~(st_wr & reg_wdata[2]));
      stall_sw <= clr_feat ? 1'b0 : (stall_sw | fst_go);
      stall_pe <= proto_err | (stall_pe & ~clr_feat);
    end
  end

  always_ff @(posedge clk) begin
    if (byte_wr) mem[wsel][wptr[AW-1:0]] <= rx_byte;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {3'b000, ien, fst, sst, rne, rpc};
      2'd1:    reg_rdata = rne ? mem[rsel][rptr[AW-1:0]] : 8'h00;
      2'd2:    reg_rdata = {7'b0000000, intf};
      default: reg_rdata = 8'h00;
    endcase
  end

  p_stall_tok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out && stalled |=> hs_valid && hs_code == HS_STALL);

  p_nak_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out && !stalled && both_full |=> hs_valid && hs_code == HS_NAK);

  p_fst_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fst && !txn_busy && !clr_feat && !(st_wr && reg_wdata[3]) |=> !fst && sst && stall_sw);

  p_fst_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fst && txn_busy |=> fst && !stall_sw || fst && $past(stall_sw));

  p_pe_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err && !fst && !sst |=> !sst && stall_pe);

  p_rpc_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rpc && !(st_wr && reg_wdata[0]) |=> rpc);

  p_irq_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intf) |-> $past(ien));

  p_hs_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid && !$past(tok_out) |-> 1'b0);

  always_ff @(posedge clk) begin
    if (rst_n) begin
      p_len_cap_r10: assert (wptr <= CAP) else $error("write pointer past buffer end");
    end
  end

endmodule

// File: tb/usb_out_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_out_ep_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_out = 0, rx_we = 0, rx_end = 0, rx_ok = 0;
  logic       proto_err = 0, clr_feat = 0, txn_busy = 0;
  logic [7:0] rx_byte = 0;
  logic [1:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [4:0] reg_wdata = 0;
  logic       hs_valid, irq;
  logic [1:0] hs_code;
  logic [7:0] reg_rdata;

  usb_out_ep_ctrl #(.BUF_BYTES(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_we(rx_we), .rx_byte(rx_byte),
    .rx_end(rx_end), .rx_ok(rx_ok), .proto_err(proto_err), .clr_feat(clr_feat),
    .txn_busy(txn_busy), .hs_valid(hs_valid), .hs_code(hs_code), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, wd = 0;
  bit done = 0;
  string ph = "R1 reset";

  logic [7:0] fifo_q[$];
  int         plen[$];
  logic [7:0] cur[$];
  bit m_hsv, m_acc, m_rpc, m_sst, m_fst, m_ien, m_int, m_sw, m_pe;
  logic [1:0] m_hsc;
  string m_hstag = "R2";

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, ph, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      fifo_q.delete(); plen.delete(); cur.delete();
      {m_hsv, m_acc, m_rpc, m_sst, m_fst, m_ien, m_int, m_sw, m_pe} = '0;
      m_hsc = 0;
    end else begin
      bit do_pop, rset, go, swr;
      do_pop = reg_rd && reg_addr == 1 && fifo_q.size() > 0;
      swr = reg_wr && reg_addr == 0;
      go = m_fst && !txn_busy && !clr_feat;
      rset = 0;
      m_hsv = tok_out;
      if (tok_out) begin
        if (m_sw || m_pe) begin m_hsc = 2; m_hstag = m_pe ? "R8" : "R7"; end
        else if (plen.size() == 2) begin m_hsc = 1; m_hstag = "R5"; end
        else begin m_hsc = 0; m_hstag = "R2"; end
        m_acc = (m_hsc == 0);
        cur.delete();
      end
      if (do_pop) begin
        void'(fifo_q.pop_front());
        plen[0] = plen[0] - 1;
        if (plen[0] == 0) void'(plen.pop_front());
      end
      if (!tok_out && m_acc) begin
        if (rx_end) begin
          m_acc = 0;
          if (rx_ok) begin
            rset = 1;
            if (cur.size() > 0) begin
              plen.push_back(cur.size());
              foreach (cur[i]) fifo_q.push_back(cur[i]);
            end
          end
        end else if (rx_we && cur.size() < 64) begin
          cur.push_back(rx_byte);
        end
      end
      m_int = (rset && m_ien) || (m_int && !(reg_wr && reg_addr == 2 && reg_wdata[0]));
      m_rpc = rset || (m_rpc && !(swr && reg_wdata[0]));
      if (swr) m_ien = reg_wdata[4];
      m_fst = (swr && reg_wdata[3]) || (m_fst && !go);
      m_sst = go || (m_sst && !(swr && reg_wdata[2]));
      m_sw = clr_feat ? 0 : (m_sw || go);
      m_pe = proto_err || (m_pe && !clr_feat);
    end
    #1;
    begin
      logic [7:0] st;
      bit rne;
      rne = fifo_q.size() > 0;
      st = {3'b000, m_ien, m_fst, m_sst, rne, m_rpc};
      chk(!rst_n ? "R1" : "R2", hs_valid, m_hsv);
      if (m_hsv) chk(m_hstag, hs_code, m_hsc);
      chk(!rst_n ? "R1" : "R3", irq, m_int);
      case (reg_addr)
        2'd0: begin
          chk(!rst_n ? "R1" : "R3", reg_rdata[0], st[0]);
          chk("R9", reg_rdata[1], st[1]);
          chk(!rst_n ? "R1" : "R6", reg_rdata[4:2], st[4:2]);
          chk("R1", reg_rdata[7:5], 0);
        end
        2'd1: chk("R9", reg_rdata, rne ? fifo_q[0] : 8'h00);
        2'd2: chk("R3", reg_rdata, {7'b0, m_int});
        default: chk("R1", reg_rdata, 0);
      endcase
    end
  end

  task automatic clr_in();
    tok_out = 0; rx_we = 0; rx_end = 0; rx_ok = 0; proto_err = 0; clr_feat = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); clr_in(); end
  endtask

  task automatic token();
    @(negedge clk); clr_in(); tok_out = 1;
    idle(1);
  endtask

  task automatic send_pkt(int n, logic [7:0] base, bit ok);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clr_in(); rx_we = 1; rx_byte = base + 8'(i);
    end
    @(negedge clk); clr_in(); rx_end = 1; rx_ok = ok;
    idle(1);
  endtask

  task automatic wreg(logic [1:0] a, logic [4:0] d);
    @(negedge clk); clr_in(); reg_wr = 1; reg_addr = a; reg_wdata = d;
    idle(1);
  endtask

  task automatic rreg(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clr_in(); reg_rd = 1; reg_addr = 2'd1;
    end
    idle(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", ph, wd, 20000);
      finish_run();
    end
  end

  initial begin
    idle(5);
    @(negedge clk); rst_n = 1;
    ph = "R3 enable and first packet";
    wreg(0, 5'h10);
    token(); send_pkt(5, 8'h10, 1);
    ph = "R9 second packet fills both buffers";
    token(); send_pkt(3, 8'h40, 1);
    ph = "R5 NAK with both buffers full";
    token(); send_pkt(4, 8'h80, 1);
    ph = "R4 write zero keeps flags";
    wreg(0, 5'h10); wreg(2, 5'h00);
    ph = "R4 write one clears flags";
    wreg(0, 5'h11); wreg(2, 5'h01);
    ph = "R9 partial drain";
    rreg(2);
    ph = "R6 force stall held by busy";
    txn_busy = 1;
    wreg(0, 5'h18);
    idle(4);
    txn_busy = 0;
    idle(2);
    ph = "R7 stall on tokens";
    token(); send_pkt(2, 8'hA0, 1);
    token();
    ph = "R9 data kept through stall";
    rreg(6);
    clr_feat = 1; idle(1);
    ph = "R7 normal after clear with sent flag set";
    token(); send_pkt(2, 8'hC0, 1);
    rreg(2);
    wreg(0, 5'h14);
    ph = "R8 protocol stall";
    @(negedge clk); clr_in(); proto_err = 1;
    idle(1);
    token(); token();
    @(negedge clk); clr_in(); clr_feat = 1;
    idle(1);
    token(); send_pkt(1, 8'h55, 1);
    rreg(1);
    ph = "R10 over-long packet";
    token(); send_pkt(70, 8'h00, 1);
    rreg(64);
    ph = "R3 bad packet end";
    wreg(0, 5'h11); wreg(2, 5'h01);
    token(); send_pkt(6, 8'h33, 0);
    ph = "R3 interrupt disabled";
    wreg(0, 5'h00);
    token(); send_pkt(3, 8'h66, 1);
    ph = "R6 force stall while idle";
    wreg(0, 5'h09);
    token(); token();
    rreg(3);
    idle(4);
    finish_run();
  end

endmodule